// File: doc/BRIEF.md
# Serial ADC host controller

This block is the host-side master for a 10-bit serial analog-to-digital converter. The converter is addressed by a 4-bit channel number. A client hands the controller a channel number on a valid/ready handshake. The controller then runs one serial frame:

- it lowers chip select;
- it waits a setup time;
- it issues ten I/O clock pulses, shifting the channel address out MSB first while the converter's 10-bit answer is shifted in;
- it raises chip select and holds off the next frame for the conversion time.

The converter always answers with the conversion started by the previous frame. For this reason the controller remembers the channel of the last request and attaches it to the result it reads back. The first result after reset has no earlier request behind it, so it is marked untagged. The I/O clock half-period, the chip-select setup time and the conversion gap are parameters counted in host clock cycles.

Top module: `serial_adc_host`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `cs_n` is 1, `io_clk` is 0, `req_ready` is 1 and `res_valid` is 0.
- R2: `req_ready` is 1 exactly when no frame is in progress. A frame starts on a cycle with `req_valid` and `req_ready` both high, and uses the channel present on `req_chan` in that cycle. Changes on `req_chan` while `req_ready` is low have no effect on the address shifted out.
- R3: `cs_n` falls in the cycle after the handshake. It stays low for CS_SETUP cycles before the first rise of `io_clk`.
- R4: Each frame has exactly ten `io_clk` pulses, each high for HALF_DIV cycles and low for HALF_DIV cycles. `io_clk` is high only while `cs_n` is low.
- R5: `addr_out` carries the four channel bits MSB first, one bit per pulse. Each bit is stable across its rising edge of `io_clk`. From the fifth pulse onward `addr_out` is 0.
- R6: `sdata_in` is sampled in the last cycle of each high phase of `io_clk`, just before that pulse's falling edge. The ten samples are shifted in MSB first.
- R7: `res_valid` is a one-cycle pulse in the first cycle after the tenth falling edge of `io_clk`. In that cycle `res_data` holds the ten sampled bits.
- R8: `res_chan` gives the channel of the previous frame's request. `res_tagged` is 0, with `res_chan` 0, for the first frame after reset, and 1 after that.
- R9: After the tenth falling edge, `cs_n` stays low for HALF_DIV more cycles and then goes high. `req_ready` returns exactly CONV_GAP cycles after the tenth falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Channel request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| req_chan | input | ADDR_W | Channel number to convert |
| cs_n | output | 1 | Converter chip select, active low |
| io_clk | output | 1 | Serial I/O clock to the converter |
| addr_out | output | 1 | Serial channel address to the converter |
| sdata_in | input | 1 | Serial result from the converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | DATA_W | Conversion result, MSB first as received |
| res_chan | output | ADDR_W | Channel the result belongs to |
| res_tagged | output | 1 | Result belongs to a real earlier request |

## Verification
A wrong sequencer state or count shows at the ports within one cycle as a misplaced edge on `cs_n`, `io_clk` or `req_ready`. The bench compares all three against its timing model on every cycle. A wrong sample point or a wrong shift direction stays hidden until the end of the frame, and then appears as a mismatch in `res_data` against the word the bench's converter model sent. A stale or early-updated channel tag appears one frame later, in `res_chan` or `res_tagged`, and this includes the frame after a reset taken mid-frame.

// File: rtl/serial_adc_host.sv
module serial_adc_host #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 10,
  parameter int HALF_DIV = 4,
  parameter int CS_SETUP = 8,
  parameter int CONV_GAP = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_chan,
  output logic              cs_n,
  output logic              io_clk,
  output logic              addr_out,
  input  logic              sdata_in,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [ADDR_W-1:0] res_chan,
  output logic              res_tagged
);

  localparam int GAP_CYC = CONV_GAP - HALF_DIV;
  localparam int CMAX0   = (CS_SETUP > GAP_CYC) ? CS_SETUP : GAP_CYC;
  localparam int CMAX    = (CMAX0 > HALF_DIV) ? CMAX0 : HALF_DIV;
  localparam int CW      = $clog2(CMAX + 1);
  localparam int BW      = $clog2(DATA_W);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_HI, S_LO, S_TAIL, S_GAP} st_t;

  st_t               st, st_n;
  logic [CW-1:0]     cnt, cnt_n;
  logic [BW-1:0]     bitn;
  logic [ADDR_W-1:0] cur_chan, prev_chan, addr_sh;
  logic              prev_ok;
  logic [DATA_W-1:0] shreg;

  wire cnt_done = (cnt == '0);
  wire hs       = req_valid && req_ready;
  wire last     = (bitn == BW'(DATA_W - 1));
  wire fall_now = (st == S_HI) && cnt_done;

  assign req_ready = (st == S_IDLE);
  assign addr_out  = addr_sh[ADDR_W-1];

  always_comb begin
    st_n  = st;
    cnt_n = cnt_done ? cnt : cnt - 1'b1;
    case (st)
      S_IDLE:  if (hs) begin
                 st_n  = S_SETUP;
                 cnt_n = CW'(CS_SETUP - 1);
               end
      S_SETUP: if (cnt_done) begin
                 st_n  = S_HI;
                 cnt_n = CW'(HALF_DIV - 1);
               end
      S_HI:    if (cnt_done) begin
                 st_n  = last ? S_TAIL : S_LO;
                 cnt_n = CW'(HALF_DIV - 1);
               end
      S_LO:    if (cnt_done) begin
                 st_n  = S_HI;
                 cnt_n = CW'(HALF_DIV - 1);
               end
      S_TAIL:  if (cnt_done) begin
                 st_n  = S_GAP;
                 cnt_n = CW'(GAP_CYC - 1);
               end
      S_GAP:   if (cnt_done) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      io_clk <= 1'b0;
      cs_n   <= 1'b1;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      io_clk <= (st_n == S_HI);
      cs_n   <= (st_n == S_IDLE) || (st_n == S_GAP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitn     <= '0;
      cur_chan <= '0;
      addr_sh  <= '0;
      shreg    <= '0;
    end else if (hs) begin
      bitn     <= '0;
      cur_chan <= req_chan;
      addr_sh  <= req_chan;
    end else if (fall_now) begin
      bitn    <= bitn + 1'b1;
      addr_sh <= addr_sh << 1;
      shreg   <= {shreg[DATA_W-2:0], sdata_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_data   <= '0;
      res_chan   <= '0;
      res_tagged <= 1'b0;
      prev_chan  <= '0;
      prev_ok    <= 1'b0;
    end else begin
      res_valid <= fall_now && last;
      if (fall_now && last) begin
        res_data   <= {shreg[DATA_W-2:0], sdata_in};
        res_chan   <= prev_chan;
        res_tagged <= prev_ok;
        prev_chan  <= cur_chan;
        prev_ok    <= 1'b1;
      end
    end
  end

  AST_IOCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) io_clk |-> !cs_n); // R4
  AST_READY_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (cs_n && !io_clk)); // R2
  AST_CHAN_HELD:      assert property (@(posedge clk) disable iff (!rst_n) (!cs_n && $past(!cs_n)) |-> $stable(cur_chan)); // R2
  AST_SETUP_NO_EDGE:  assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> !io_clk); // R3
  AST_ADDR_AT_RISE:   assert property (@(posedge clk) disable iff (!rst_n) $rose(io_clk) |-> $stable(addr_out)); // R5
  AST_RES_PULSE:      assert property (@(posedge clk) disable iff (!rst_n) res_valid |=> !res_valid); // R7
  AST_RES_IN_TAIL:    assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> (!cs_n && !io_clk)); // R9
  AST_TAG_STICKY:     assert property (@(posedge clk) disable iff (!rst_n) (res_valid && $past(prev_ok)) |-> res_tagged); // R8

endmodule

// File: tb/serial_adc_host_bench.sv
`timescale 1ns/1ps
module serial_adc_host_bench;

  localparam int H    = 4;
  localparam int CS   = 8;
  localparam int CONV = 96;
  localparam int GAP  = CONV - H;
  localparam int ENDT = CS + 20*H + GAP;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [3:0] req_chan = 4'h0;
  logic       cs_n, io_clk, addr_out;
  logic       sdata_in = 1'b0;
  logic       res_valid, res_tagged;
  logic [9:0] res_data;
  logic [3:0] res_chan;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  serial_adc_host #(.ADDR_W(4), .DATA_W(10), .HALF_DIV(H), .CS_SETUP(CS), .CONV_GAP(CONV)) u_serial_adc_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .cs_n(cs_n), .io_clk(io_clk), .addr_out(addr_out), .sdata_in(sdata_in),
    .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan), .res_tagged(res_tagged));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model and converter model
  bit       busy = 0, hs_pend = 0, prev_ok_m = 0, exp_ok = 0;
  int       t = 0, nrise = 0, nfall = 0, fcnt = 0;
  logic [3:0] hs_chan = 0, cur_req_m = 0, prev_chan_m = 0, exp_chan = 0, addr_coll = 0;
  logic [9:0] dev_sr = 0, dev_next = 10'h2A5, exp_data = 0;
  bit       prev_cs = 1, prev_io = 0;

  always @(negedge clk) begin
    bit e_cs, e_io, e_rdy, e_rv;
    int u;
    if (!rst_n) begin
      busy = 0; t = 0; hs_pend = 0; prev_ok_m = 0; prev_chan_m = 0;
    end else begin
      if (busy) begin t++; if (t > ENDT) busy = 0; end
      if (hs_pend) begin
        busy = 1; t = 1;
        exp_chan = prev_chan_m; exp_ok = prev_ok_m;
        prev_chan_m = hs_chan; prev_ok_m = 1; cur_req_m = hs_chan;
      end
    end
    u     = t - CS - 1;
    e_io  = busy && u >= 0 && u < 20*H && ((u / H) % 2 == 0);
    e_cs  = !(busy && t <= CS + 20*H);
    e_rdy = !busy;
    e_rv  = busy && (t == CS + 19*H + 1);
    if (!rst_n || !prev_ok_m && !busy) begin
      chk(cs_n == e_cs, "R1", "cs_n", cs_n, e_cs);
      chk(io_clk == e_io, "R1", "io_clk", io_clk, e_io);
      chk(req_ready == e_rdy, "R1", "req_ready", req_ready, e_rdy);
      chk(res_valid == 1'b0, "R1", "res_valid", res_valid, 0);
    end else begin
      chk(cs_n == e_cs, (t > CS + 20*H) ? "R9" : "R3", "cs_n", cs_n, e_cs);
      chk(io_clk == e_io, "R4", "io_clk", io_clk, e_io);
      chk(req_ready == e_rdy, (t > ENDT - 2) ? "R9" : "R2", "req_ready", req_ready, e_rdy);
      chk(res_valid == e_rv, "R7", "res_valid", res_valid, e_rv);
      if (res_valid && e_rv) begin
        chk(res_data == exp_data, "R6", "res_data", res_data, exp_data);
        chk(res_chan == exp_chan, "R8", "res_chan", res_chan, exp_chan);
        chk(res_tagged == exp_ok, "R8", "res_tagged", res_tagged, exp_ok);
      end
    end
    hs_pend = rst_n && e_rdy && req_valid;
    hs_chan = req_chan;

    if (cs_n) begin nrise = 0; nfall = 0; end
    if (!cs_n && prev_cs) begin dev_sr = dev_next; exp_data = dev_next; addr_coll = 0; end
    if (!cs_n && io_clk && !prev_io) begin
      if (nrise < 4) addr_coll = {addr_coll[2:0], addr_out};
      else chk(addr_out == 1'b0, "R5", "addr_out pad", addr_out, 0);
      nrise++;
    end
    if (!cs_n && !io_clk && prev_io) begin
      dev_sr = dev_sr << 1;
      nfall++;
      if (nfall == 10) begin
        chk(addr_coll == cur_req_m, "R5", "serial address", addr_coll, cur_req_m);
        dev_next = {addr_coll, 6'(fcnt * 7 + 3)};
        fcnt++;
      end
    end
    sdata_in = dev_sr[9];
    prev_cs = cs_n;
    prev_io = io_clk;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic single(input logic [3:0] ch);
    @(posedge clk); #2;
    req_valid = 1'b1; req_chan = ch;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic burst_one(input logic [3:0] ch);
    req_chan = ch;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2;
    req_chan = ~ch;            // R2: ignored while busy
    repeat (30) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    single(4'h5);                // first result untagged (R8)
    single(4'hA);
    repeat (50) @(posedge clk);
    single(4'h0);
    @(posedge clk); #2;
    req_valid = 1'b1;
    burst_one(4'hF);
    burst_one(4'hB);
    burst_one(4'h6);
    burst_one(4'h9);
    req_valid = 1'b0;
    single(4'h7);
    repeat (40) @(posedge clk);
    #2 rst_n = 1'b0;             // reset mid-frame (R1)
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    single(4'h3);
    single(4'hC);
    single(4'h1);
    repeat (ENDT + 20) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule